// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block is the device-side engine behind a command mailbox in a memory-expander register file. The host loads a command word and then rings a doorbell. The command word holds a command set, a command code and the length of the input payload. The engine then owns the mailbox until it has finished.

The engine looks the 16-bit opcode up in a small fixed table. Each table entry names a handler and the input length that handler expects. If the supplied length fits, the handler runs. Handlers are small register-backed responders: zero fillers, a length echo, and a timestamp store and recall.

On completion the engine writes three things:
- the return code into the status register;
- a command word whose set and code fields are zero and whose length field holds the output length;
- the first 64 bits of the output payload, for the handlers that produce data.

It then drops the doorbell to hand the mailbox back to the host. Only one command is in flight at a time.

Top module: `mbx_dispatcher`

## Requirements
- R1: After a synchronous active-low reset, `cmd_reg`, `status_rc` and `payload_out` are all zero and `doorbell` is low.
- R2: A rising edge on `ring` seen while `doorbell` is low raises `doorbell` at the next clock edge. `doorbell` then stays high for exactly three cycles and falls by itself.
- R3: A `ring` level held high starts only one command. A rising edge of `ring` that arrives while `doorbell` is high starts nothing, and `doorbell` stays low after the running command retires.
- R4: `cmd_we` writes are ignored while `doorbell` is high, so the result belongs to the command word that was loaded before the ring.
- R5: An opcode not in the table completes with return code 0x0003 and output length 0.
- R6: A table opcode whose fixed expected length differs from the supplied length completes with code 0x0016 and output length 0. Its handler has no effect: the stored timestamp and `payload_out` are unchanged.
- R7: Command word layout: bits [7:0] hold the command code, bits [15:8] the command set (the upper byte of the opcode), and bits [31:16] the length. On completion bits [15:0] read zero and bits [31:16] hold the output length.
- R8: Zero-fill handlers, each returning code 0 and zeroing `payload_out`:
  - opcode 0x0100 expects 1 input byte and reports output length 0x20;
  - opcode 0x0102 expects 0 input bytes and reports output length 4.
- R9: Timestamp handlers:
  - opcode 0x0301 expects 8 bytes, stores `payload_in` and reports length 0;
  - opcode 0x0300 expects 0 bytes, returns the stored value on `payload_out` and reports length 8.
- R10: Echo handlers return code 0 and report the input length as output length:
  - opcode 0x0101 accepts any input length (an expected length of all ones);
  - opcode 0x0103 expects exactly 4 bytes.
- R11: An output length above `PAYLOAD_BYTES` (default 256) is clamped to `PAYLOAD_BYTES`, and the code becomes 0x0004 (internal error).
- R12: `payload_out` changes only on a successful zero-fill or timestamp-get command. It never changes while `doorbell` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | LEN_W+16 | Command word written by the host |
| ring | input | 1 | Doorbell request level; its rising edge starts a command |
| payload_in | input | DATA_W | First bytes of the input payload |
| cmd_reg | output | LEN_W+16 | Command word register |
| status_rc | output | 16 | Return code of the last completed command |
| doorbell | output | 1 | High while a command is owned by the engine |
| payload_out | output | DATA_W | First bytes of the output payload |

## Verification
Each command has a fixed schedule, counted from the clock edge that samples the rising edge of `ring`:
- `doorbell` is high after that edge;
- the command is decoded one edge later;
- the results are written one edge after that;
- `doorbell` falls on the third edge after it rose.

The bench drives inputs on falling edges. It checks `doorbell` on the first and third falling edges after the ring and checks every result on the fourth, when `doorbell` must be low and all registers final. The reference values come from a bench model of the opcode table and the clamp rule, fed both random and directed opcodes and lengths.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// mbx_pkg: shared types, return codes and the supported-command table.
// Assumes opcodes are {command set, command code}, 16 bits.
package mbx_pkg;

    typedef enum logic [1:0] {
        H_ZERO   = 2'd0,   // output zero-filled, fixed output length
        H_ECHO   = 2'd1,   // output length equals input length
        H_TS_GET = 2'd2,   // return stored timestamp
        H_TS_SET = 2'd3    // store timestamp from payload
    } hkind_e;

    localparam int          N_CMDS      = 6;
    localparam logic [15:0] EXP_ANY     = 16'hFFFF;

    localparam logic [15:0] RC_OK       = 16'h0000;
    localparam logic [15:0] RC_UNSUP    = 16'h0003;
    localparam logic [15:0] RC_INTERNAL = 16'h0004;
    localparam logic [15:0] RC_BADLEN   = 16'h0016;

    // Opcode of table entry i.
    function automatic logic [15:0] tab_opc(input int i);
        case (i)
            0: return 16'h0100;
            1: return 16'h0101;
            2: return 16'h0102;
            3: return 16'h0103;
            4: return 16'h0300;
            default: return 16'h0301;
        endcase
    endfunction

    // Expected input length of entry i (EXP_ANY accepts anything).
    function automatic logic [15:0] tab_exp(input int i);
        case (i)
            0: return 16'd1;
            1: return EXP_ANY;
            2: return 16'd0;
            3: return 16'd4;
            4: return 16'd0;
            default: return 16'd8;
        endcase
    endfunction

    // Handler kind of entry i.
    function automatic hkind_e tab_kind(input int i);
        case (i)
            0: return H_ZERO;
            1: return H_ECHO;
            2: return H_ZERO;
            3: return H_ECHO;
            4: return H_TS_GET;
            default: return H_TS_SET;
        endcase
    endfunction

    // Fixed output length of entry i (unused by echo handlers).
    function automatic logic [15:0] tab_olen(input int i);
        case (i)
            0: return 16'h0020;
            2: return 16'd4;
            4: return 16'd8;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/mbx_doorbell.sv
`timescale 1ns/1ps
// mbx_doorbell: detects the rising edge of the ring request and sequences
// one command through decode, write-back and release. Assumes ring is
// synchronous to clk. Edges arriving while busy are consumed and dropped.
module mbx_doorbell (
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    output logic doorbell,
    output logic st_dec,
    output logic st_wb
);
    typedef enum logic [1:0] {S_IDLE, S_DEC, S_WB, S_DONE} state_e;

    state_e state_q;
    logic   ring_q;
    logic   ring_rise;

    assign ring_rise = ring && !ring_q;

    // Remember the previous ring level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= 1'b0;
        else        ring_q <= ring;
    end

    // Single-outstanding command sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:  if (ring_rise) state_q <= S_DEC;
                S_DEC:   state_q <= S_WB;
                S_WB:    state_q <= S_DONE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign doorbell = (state_q != S_IDLE);
    assign st_dec   = (state_q == S_DEC);
    assign st_wb    = (state_q == S_WB);
endmodule

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
// mbx_decode: looks the opcode up in the command table and checks the
// supplied input length against the entry's expectation. Purely
// combinational; assumes table opcodes are unique.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [15:0]      opcode,
    input  logic [LEN_W-1:0] in_len,
    output logic             hit,
    output logic             len_ok,
    output hkind_e           kind,
    output logic [LEN_W-1:0] fixed_olen
);
    logic [N_CMDS-1:0] match;
    logic [15:0]       exp_len;

    // One comparator per table entry.
    for (genvar g = 0; g < N_CMDS; g++) begin : g_match
        assign match[g] = (opcode == tab_opc(g));
    end

    // Select the matching entry's attributes.
    always_comb begin
        hit        = 1'b0;
        kind       = H_ZERO;
        exp_len    = 16'd0;
        fixed_olen = '0;
        for (int i = 0; i < N_CMDS; i++) begin
            if (match[i]) begin
                hit        = 1'b1;
                kind       = tab_kind(i);
                exp_len    = tab_exp(i);
                fixed_olen = LEN_W'(tab_olen(i));
            end
        end
    end

    // Length check: all-ones expectation accepts any length.
    assign len_ok = (exp_len == EXP_ANY) || (LEN_W'(exp_len) == in_len);
endmodule

// File: rtl/mbx_exec.sv
`timescale 1ns/1ps
// mbx_exec: produces the handler result (return code, clamped output
// length, payload and timestamp write enables) from the decode outcome.
// Combinational; side effects are enabled only for a successful result.
module mbx_exec
    import mbx_pkg::*;
#(
    parameter int LEN_W         = 16,
    parameter int DATA_W        = 64,
    parameter int PAYLOAD_BYTES = 256
) (
    input  logic              hit,
    input  logic              len_ok,
    input  hkind_e            kind,
    input  logic [LEN_W-1:0]  fixed_olen,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] ts_val,
    output logic [15:0]       rc,
    output logic [LEN_W-1:0]  out_len,
    output logic              pay_we,
    output logic [DATA_W-1:0] pay_val,
    output logic              ts_we
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(PAYLOAD_BYTES);

    logic [LEN_W-1:0] raw_len;
    logic             want_pay;
    logic             want_ts;

    // Handler body: raw output length and requested side effects.
    always_comb begin
        raw_len  = '0;
        want_pay = 1'b0;
        want_ts  = 1'b0;
        pay_val  = '0;
        case (kind)
            H_ZERO:   begin raw_len = fixed_olen; want_pay = 1'b1; end
            H_ECHO:   raw_len = in_len;
            H_TS_GET: begin raw_len = fixed_olen; want_pay = 1'b1; pay_val = ts_val; end
            default:  want_ts = 1'b1;
        endcase
    end

    // Return code, clamping, and gating of side effects.
    always_comb begin
        rc      = RC_OK;
        out_len = raw_len;
        pay_we  = 1'b0;
        ts_we   = 1'b0;
        if (!hit) begin
            rc      = RC_UNSUP;
            out_len = '0;
        end else if (!len_ok) begin
            rc      = RC_BADLEN;
            out_len = '0;
        end else if (raw_len > MAX_LEN) begin
            rc      = RC_INTERNAL;
            out_len = MAX_LEN;
        end else begin
            pay_we  = want_pay;
            ts_we   = want_ts;
        end
    end
endmodule

// File: rtl/mbx_dispatcher.sv
`timescale 1ns/1ps
// mbx_dispatcher: mailbox command engine top. Holds the command, status,
// payload and timestamp registers; decodes and executes one command per
// doorbell and writes the results back before releasing the doorbell.
// Assumes the host only writes the command word while doorbell is low.
module mbx_dispatcher
    import mbx_pkg::*;
#(
    parameter int LEN_W         = 16,
    parameter int DATA_W        = 64,
    parameter int PAYLOAD_BYTES = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_we,
    input  logic [LEN_W+15:0]   cmd_wdata,
    input  logic                ring,
    input  logic [DATA_W-1:0]   payload_in,
    output logic [LEN_W+15:0]   cmd_reg,
    output logic [15:0]         status_rc,
    output logic                doorbell,
    output logic [DATA_W-1:0]   payload_out
);
    localparam int CMD_W = LEN_W + 16;

    logic              st_dec, st_wb;
    logic [CMD_W-1:0]  cmd_q;
    logic [15:0]       status_q;
    logic [DATA_W-1:0] pay_q, ts_q;

    logic              hit, len_ok;
    hkind_e            kind;
    logic [LEN_W-1:0]  fixed_olen;
    logic [15:0]       rc;
    logic [LEN_W-1:0]  out_len;
    logic              pay_we, ts_we;
    logic [DATA_W-1:0] pay_val;

    logic [15:0]       res_rc_q;
    logic [LEN_W-1:0]  res_len_q;
    logic              res_pay_we_q;
    logic [DATA_W-1:0] res_pay_q;

    mbx_doorbell u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring     (ring),
        .doorbell (doorbell),
        .st_dec   (st_dec),
        .st_wb    (st_wb)
    );

    mbx_decode #(.LEN_W(LEN_W)) u_dec (
        .opcode     (cmd_q[15:0]),
        .in_len     (cmd_q[CMD_W-1:16]),
        .hit        (hit),
        .len_ok     (len_ok),
        .kind       (kind),
        .fixed_olen (fixed_olen)
    );

    mbx_exec #(
        .LEN_W         (LEN_W),
        .DATA_W        (DATA_W),
        .PAYLOAD_BYTES (PAYLOAD_BYTES)
    ) u_exec (
        .hit        (hit),
        .len_ok     (len_ok),
        .kind       (kind),
        .fixed_olen (fixed_olen),
        .in_len     (cmd_q[CMD_W-1:16]),
        .ts_val     (ts_q),
        .rc         (rc),
        .out_len    (out_len),
        .pay_we     (pay_we),
        .pay_val    (pay_val),
        .ts_we      (ts_we)
    );

    // Command word: host writes when idle, engine rewrites at write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cmd_q <= '0;
        else if (st_wb)               cmd_q <= {res_len_q, 16'h0000};
        else if (cmd_we && !doorbell) cmd_q <= cmd_wdata;
    end

    // Capture the handler result in the decode cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_rc_q     <= '0;
            res_len_q    <= '0;
            res_pay_we_q <= 1'b0;
            res_pay_q    <= '0;
        end else if (st_dec) begin
            res_rc_q     <= rc;
            res_len_q    <= out_len;
            res_pay_we_q <= pay_we;
            res_pay_q    <= pay_val;
        end
    end

    // Timestamp store, written by a successful timestamp-set command.
    always_ff @(posedge clk) begin
        if (!rst_n)               ts_q <= '0;
        else if (st_dec && ts_we) ts_q <= payload_in;
    end

    // Status and output payload write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            pay_q    <= '0;
        end else if (st_wb) begin
            status_q <= res_rc_q;
            if (res_pay_we_q) pay_q <= res_pay_q;
        end
    end

    assign cmd_reg     = cmd_q;
    assign status_rc   = status_q;
    assign payload_out = pay_q;
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
// mbx_checker: temporal properties of the mailbox engine, seen at its ports.
module mbx_checker #(
    parameter int LEN_W         = 16,
    parameter int DATA_W        = 64,
    parameter int PAYLOAD_BYTES = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring,
    input logic              doorbell,
    input logic [LEN_W+15:0] cmd_reg,
    input logic [15:0]       status_rc,
    input logic [DATA_W-1:0] payload_out
);
    logic ring_prev;

    // Independent copy of the previous ring level.
    always_ff @(posedge clk) begin
        if (!rst_n) ring_prev <= 1'b0;
        else        ring_prev <= ring;
    end

    a_r2_ring_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && !ring_prev && !doorbell) |=> doorbell);

    a_r2_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doorbell) |=> doorbell ##1 doorbell ##1 !doorbell);

    a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doorbell) |=> $stable(cmd_reg));

    a_r7_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doorbell) |-> (cmd_reg[15:0] == 16'h0000));

    a_r5_unsup_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(doorbell) && status_rc == 16'h0003) |-> (cmd_reg[LEN_W+15:16] == '0));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doorbell) |-> (cmd_reg[LEN_W+15:16] <= LEN_W'(PAYLOAD_BYTES)));

    a_r12_payload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(payload_out) |-> doorbell);
endmodule

bind mbx_dispatcher mbx_checker #(
    .LEN_W         (LEN_W),
    .DATA_W        (DATA_W),
    .PAYLOAD_BYTES (PAYLOAD_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring        (ring),
    .doorbell    (doorbell),
    .cmd_reg     (cmd_reg),
    .status_rc   (status_rc),
    .payload_out (payload_out)
);

// File: tb/sim_mbx_dispatcher.sv
`timescale 1ns/1ps
module sim_mbx_dispatcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        ring = 1'b0;
    logic [63:0] payload_in = '0;
    logic [31:0] cmd_reg;
    logic [15:0] status_rc;
    logic        doorbell;
    logic [63:0] payload_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [63:0] m_ts  = '0;
    logic [63:0] m_pay = '0;

    always #2 clk = ~clk;

    mbx_dispatcher u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .ring(ring), .payload_in(payload_in), .cmd_reg(cmd_reg),
        .status_rc(status_rc), .doorbell(doorbell), .payload_out(payload_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of the command table and result rules.
    function automatic void model(input logic [15:0] opc, input logic [15:0] len,
                                  input logic [63:0] pin,
                                  output logic [15:0] rc, output logic [15:0] olen);
        logic [15:0] exp_len;
        logic [15:0] raw;
        bit any, pz, tg, tsw, known;
        any = 0; pz = 0; tg = 0; tsw = 0; known = 1; raw = 0; exp_len = 0;
        case (opc)
            16'h0100: begin exp_len = 1; raw = 16'h20; pz = 1; end
            16'h0101: begin any = 1; raw = len; end
            16'h0102: begin exp_len = 0; raw = 4; pz = 1; end
            16'h0103: begin exp_len = 4; raw = len; end
            16'h0300: begin exp_len = 0; raw = 8; tg = 1; end
            16'h0301: begin exp_len = 8; raw = 0; tsw = 1; end
            default:  known = 0;
        endcase
        if (!known) begin rc = 16'h0003; olen = 0; end
        else if (!any && len != exp_len) begin rc = 16'h0016; olen = 0; end
        else if (raw > 16'd256) begin rc = 16'h0004; olen = 16'd256; end
        else begin
            rc = 16'h0000; olen = raw;
            if (pz) m_pay = '0;
            if (tg) m_pay = m_ts;
            if (tsw) m_ts = pin;
        end
    endfunction

    // Load a command, ring, and check timing and results.
    task automatic run_cmd(input logic [15:0] opc, input logic [15:0] len,
                           input logic [63:0] pin, input string req);
        logic [15:0] erc, elen;
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = {len, opc}; payload_in = pin; ring = 1'b0;
        @(negedge clk);
        cmd_we = 1'b0; ring = 1'b1;
        @(negedge clk);
        chk("R2 doorbell set", {63'd0, doorbell}, 64'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R2 doorbell held", {63'd0, doorbell}, 64'd1);
        @(negedge clk);
        chk("R2 doorbell cleared", {63'd0, doorbell}, 64'd0);
        model(opc, len, pin, erc, elen);
        chk({req, " rc"}, {48'd0, status_rc}, {48'd0, erc});
        chk({req, " R7 cmd word"}, {32'd0, cmd_reg}, {32'd0, elen, 16'h0000});
        chk({req, " R12 payload"}, payload_out, m_pay);
        ring = 1'b0;
    endtask

    initial begin
        logic [15:0] opc, len;
        logic [63:0] pin;
        int sel;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd_reg", {32'd0, cmd_reg}, 64'd0);
        chk("R1 status", {48'd0, status_rc}, 64'd0);
        chk("R1 doorbell", {63'd0, doorbell}, 64'd0);
        chk("R1 payload", payload_out, 64'd0);

        run_cmd(16'h0100, 16'd1, 64'h0, "R8 records");
        run_cmd(16'h0301, 16'd8, 64'hDEAD_BEEF_0123_4567, "R9 ts set");
        run_cmd(16'h0300, 16'd0, 64'h0, "R9 ts get");
        run_cmd(16'h0301, 16'd7, 64'h1111_2222_3333_4444, "R6 bad len");
        run_cmd(16'h0300, 16'd0, 64'h0, "R6 ts unchanged");
        run_cmd(16'h0102, 16'd0, 64'h0, "R8 policy");
        run_cmd(16'h0205, 16'd3, 64'h0, "R5 unsupported");
        run_cmd(16'h0101, 16'd200, 64'h0, "R10 any len");
        run_cmd(16'h0103, 16'd4, 64'h0, "R10 fixed echo");
        run_cmd(16'h0101, 16'd300, 64'h0, "R11 clamp");
        run_cmd(16'h0101, 16'd256, 64'h0, "R11 at limit");

        // R3: held level and an edge while busy start nothing further.
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = {16'd0, 16'h0102};
        @(negedge clk); cmd_we = 1'b0; ring = 1'b1;
        @(negedge clk); ring = 1'b0;
        // R4: host writes during the busy window are ignored.
        cmd_we = 1'b1; cmd_wdata = {16'd8, 16'h0301};
        @(negedge clk); ring = 1'b1; cmd_we = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R3 no restart", {63'd0, doorbell}, 64'd0);
        chk("R4 write ignored", {32'd0, cmd_reg}, {32'd0, 16'd4, 16'h0000});
        repeat (3) @(negedge clk);
        chk("R3 level held", {63'd0, doorbell}, 64'd0);
        ring = 1'b0;

        // Random commands against the model.
        for (int i = 0; i < 60; i++) begin
            sel = $urandom % 8;
            case (sel)
                0: opc = 16'h0100; 1: opc = 16'h0101; 2: opc = 16'h0102;
                3: opc = 16'h0103; 4: opc = 16'h0300; 5: opc = 16'h0301;
                default: opc = 16'($urandom);
            endcase
            if ($urandom % 2 == 0) begin
                case (opc)
                    16'h0100: len = 1; 16'h0103: len = 4; 16'h0301: len = 8;
                    default: len = 0;
                endcase
                if (opc == 16'h0101) len = 16'($urandom % 400);
            end else begin
                len = 16'($urandom % 400);
            end
            pin = {$urandom, $urandom};
            run_cmd(opc, len, pin, "R5/R6/R8/R9/R10/R11 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule